// File: doc/BRIEF.md
# Triple-Pumped Single-Port Scratchpad Controller

This block lets a single-ported RAM serve two reads and one write in every cycle of a slow processor clock. The RAM runs on a second clock at exactly three times the processor frequency, with rising edges aligned. At each processor edge the controller registers two read addresses and one write request. During the next three RAM cycles it issues them to the RAM in a fixed order: read A, then read B, then the write. Both read words are gathered in the RAM clock domain. They are published together on the processor-clock edge that ends the slot sequence, and they stay constant for that whole processor cycle.

Requests are accepted on every processor cycle. There is no handshake and no back-pressure, because the slot schedule has a fixed capacity that always matches the request rate. A write that enables no byte lanes leaves its slot unused. Word width and depth are parameters. The full-size scratchpad is 32768 words of 32 bits. The default depth is kept small so that the behavioural RAM model stays light.

Top module: `tri_slot_sram_port`

## Requirements
- R1: Read addresses sampled at processor edge k appear as data on `rd_data_a`/`rd_data_b` from processor edge k+1 until edge k+2.
- R2: A read aimed at the address being written in the same processor cycle returns the word as it was before that write.
- R3: A write sampled at edge k is visible to reads sampled at edge k+1 and later.
- R4: Bit i of `wr_be` (i = 0..3) writes `wr_data[8i+7:8i]` into the same byte of the word. Bytes whose enable is 0 keep their old value.
- R5: When `wr_be` is 0 the memory is left unchanged.
- R6: Within one processor cycle the RAM performs at most one access per RAM cycle, in the order read A, read B, write.
- R7: While reset is asserted, and until the first request has completed, both read outputs are 0.
- R8: The read outputs change only on a RAM edge that coincides with a processor edge. They are stable at every other RAM edge.
- R9: Ports A and B are independent: equal addresses return equal data, and distinct addresses return their own words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Slow processor clock |
| clk_ram | input | 1 | RAM clock, 3x `clk_cpu`, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| rd_addr_a | input | ADDR_W | Read address, port A |
| rd_addr_b | input | ADDR_W | Read address, port B |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| wr_be | input | DATA_W/8 | Byte write enables; all zero means no write |
| rd_data_a | output | DATA_W | Read data, port A, held for one processor cycle |
| rd_data_b | output | DATA_W | Read data, port B, held for one processor cycle |

## Verification
The assertions rely on `clk_ram` running at exactly three times `clk_cpu`, with every processor rising edge landing on a RAM rising edge. Only under that condition does the slot sequence close on a processor edge. The bench generates both clocks from a single stepping loop, so this phase relation is exact by construction. It changes all request inputs on the processor falling edge, well away from either clock's rising edge. The bench also reads only addresses it has already written, or marks a read as unchecked, so no assertion or comparison ever depends on uninitialised RAM contents.

// File: rtl/tss_pkg.sv
package tss_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_RD_A = 2'd1,
    SLOT_RD_B = 2'd2,
    SLOT_WR   = 2'd3
  } slot_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/tss_phase_gen.sv
module tss_phase_gen
  import tss_pkg::*;
(
  input  logic  clk_cpu,
  input  logic  clk_ram,
  input  logic  rst_n,
  output slot_e slot
);
  logic       cpu_tog;
  logic       tog_seen;
  logic [1:0] ph_cnt;
  logic       new_cyc;

  // Flips once per processor edge; the RAM domain detects the change.
  always_ff @(posedge clk_cpu or negedge rst_n) begin
    if (!rst_n) cpu_tog <= 1'b0;
    else        cpu_tog <= ~cpu_tog;
  end

  assign new_cyc = cpu_tog ^ tog_seen;

  always_ff @(posedge clk_ram or negedge rst_n) begin
    if (!rst_n) begin
      tog_seen <= 1'b0;
      ph_cnt   <= 2'd0;
    end else begin
      tog_seen <= cpu_tog;
      if (new_cyc)             ph_cnt <= 2'd1;
      else if (ph_cnt == 2'd1) ph_cnt <= 2'd2;
      else                     ph_cnt <= 2'd0;
    end
  end

  always_comb begin
    if (new_cyc)             slot = SLOT_RD_A;
    else if (ph_cnt == 2'd1) slot = SLOT_RD_B;
    else if (ph_cnt == 2'd2) slot = SLOT_WR;
    else                     slot = SLOT_IDLE;
  end

  // R6
  rb_after_ra_chk: assert property (@(posedge clk_ram) disable iff (!rst_n)
    slot == SLOT_RD_A |=> slot == SLOT_RD_B);

  // R6
  wr_after_rb_chk: assert property (@(posedge clk_ram) disable iff (!rst_n)
    slot == SLOT_RD_B |=> slot == SLOT_WR);
endmodule

// File: rtl/tss_sp_ram.sv
module tss_sp_ram
  import tss_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[addr];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (wr_en && be[l]) mem[addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  // R6
  one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, wr_en}));
endmodule

// File: rtl/tri_slot_sram_port.sv
module tri_slot_sram_port
  import tss_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 1024,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned BE_W   = DATA_W / LANE_W
) (
  input  logic              clk_cpu,
  input  logic              clk_ram,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr_a,
  input  logic [ADDR_W-1:0] rd_addr_b,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be,
  output logic [DATA_W-1:0] rd_data_a,
  output logic [DATA_W-1:0] rd_data_b
);
  slot_e             slot;
  logic [ADDR_W-1:0] ra_q, rb_q, wa_q;
  logic [DATA_W-1:0] wd_q;
  logic [BE_W-1:0]   be_q;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_re, ram_we;
  logic [DATA_W-1:0] ram_q;
  logic [DATA_W-1:0] stage_a;

  // Request capture, processor domain.
  always_ff @(posedge clk_cpu or negedge rst_n) begin
    if (!rst_n) begin
      ra_q <= '0;
      rb_q <= '0;
      wa_q <= '0;
      wd_q <= '0;
      be_q <= '0;
    end else begin
      ra_q <= rd_addr_a;
      rb_q <= rd_addr_b;
      wa_q <= wr_addr;
      wd_q <= wr_data;
      be_q <= wr_be;
    end
  end

  tss_phase_gen u_phase (
    .clk_cpu (clk_cpu),
    .clk_ram (clk_ram),
    .rst_n   (rst_n),
    .slot    (slot)
  );

  always_comb begin
    unique case (slot)
      SLOT_RD_A: ram_addr = ra_q;
      SLOT_RD_B: ram_addr = rb_q;
      SLOT_WR:   ram_addr = wa_q;
      default:   ram_addr = '0;
    endcase
  end

  assign ram_re = (slot == SLOT_RD_A) || (slot == SLOT_RD_B);
  assign ram_we = (slot == SLOT_WR) && (|be_q);

  tss_sp_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk_ram),
    .rst_n (rst_n),
    .rd_en (ram_re),
    .wr_en (ram_we),
    .addr  (ram_addr),
    .wdata (wd_q),
    .be    (be_q),
    .rdata (ram_q)
  );

  // Holding registers, RAM domain; published on the edge shared with clk_cpu.
  always_ff @(posedge clk_ram or negedge rst_n) begin
    if (!rst_n) begin
      stage_a   <= '0;
      rd_data_a <= '0;
      rd_data_b <= '0;
    end else begin
      if (slot == SLOT_RD_B) stage_a <= ram_q;
      if (slot == SLOT_WR) begin
        rd_data_a <= stage_a;
        rd_data_b <= ram_q;
      end
    end
  end

  // R8
  hold_stable_chk: assert property (@(posedge clk_ram) disable iff (!rst_n)
    $past(slot) != SLOT_WR |-> ($stable(rd_data_a) && $stable(rd_data_b)));
endmodule

// File: tb/tri_slot_sram_port_tb.sv
`timescale 1ns/100ps
module tri_slot_sram_port_tb;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned DEPTH  = 1024;
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned BE_W   = DATA_W / 8;

  logic              clk_cpu = 1'b0, clk_ram = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [BE_W-1:0]   wr_be = '0;
  logic [DATA_W-1:0] rd_data_a, rd_data_b;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [DATA_W-1:0] ref_mem [DEPTH];
  logic [DATA_W-1:0] qa[$], qb[$];
  bit                qv[$];
  string             qt[$];

  tri_slot_sram_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk_cpu(clk_cpu), .clk_ram(clk_ram), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_data_a(rd_data_a), .rd_data_b(rd_data_b)
  );

  // 200 MHz RAM clock, processor clock at one third, rising edges aligned.
  initial begin
    forever begin
      clk_ram = 1'b1; clk_cpu = 1'b1; #2.5;
      clk_ram = 1'b0;                 #2.5;
      clk_ram = 1'b1;                 #2.5;
      clk_ram = 1'b0; clk_cpu = 1'b0; #2.5;
      clk_ram = 1'b1;                 #2.5;
      clk_ram = 1'b0;                 #2.5;
    end
  end

  task automatic check(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // One processor cycle: compare the result of the request two cycles back,
  // drive a new request, recheck just before the next processor edge.
  task automatic step(logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] b, logic [ADDR_W-1:0] w,
                      logic [DATA_W-1:0] d, logic [BE_W-1:0] be, string tag, bit va, bit vb);
    logic [DATA_W-1:0] ea, eb;
    bit v;
    string t;
    @(negedge clk_cpu);
    ea = qa.pop_front(); eb = qb.pop_front(); v = qv.pop_front(); t = qt.pop_front();
    if (v) begin
      check(t, "port A", rd_data_a, ea);
      check(t, "port B", rd_data_b, eb);
    end
    rst_n = 1'b1;
    rd_addr_a = a; rd_addr_b = b; wr_addr = w; wr_data = d; wr_be = be;
    // reads see memory before this cycle's write (R2)
    qa.push_back(ref_mem[a]); qb.push_back(ref_mem[b]);
    qv.push_back(va && vb); qt.push_back(tag);
    for (int l = 0; l < BE_W; l++)
      if (be[l]) ref_mem[w][l*8 +: 8] = d[l*8 +: 8];
    #5;
    if (v) begin
      check("R8", "port A late in cycle", rd_data_a, ea);
      check("R8", "port B late in cycle", rd_data_b, eb);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R7: outputs zero during reset
    repeat (3) @(negedge clk_cpu);
    check("R7", "port A in reset", rd_data_a, '0);
    check("R7", "port B in reset", rd_data_b, '0);
    for (int i = 0; i < 2; i++) begin
      qa.push_back('0); qb.push_back('0); qv.push_back(1'b1); qt.push_back("R7");
    end

    // Fill all words; reads trail the writes (R1, R3).
    for (int i = 0; i < DEPTH; i++) begin
      logic [ADDR_W-1:0] ia, ib;
      ia = (i == 0) ? '0 : ADDR_W'(i - 1);
      ib = ADDR_W'(i / 2);
      step(ia, ib, ADDR_W'(i), 32'hA5000000 ^ (i * 32'h00010203), 4'hF,
           "R1", i != 0, i > 1);
    end

    // R2: same-cycle read of the written word returns the old value.
    step(10'd5, 10'd5, 10'd5, 32'h11112222, 4'hF, "R2", 1, 1);
    // R3: next cycle sees the new value.
    step(10'd5, 10'd6, 10'd6, 32'h33334444, 4'hF, "R3", 1, 1);
    step(10'd6, 10'd5, 10'd7, 32'h0, 4'h0, "R3", 1, 1);

    // R4: single and mixed byte lanes.
    step(10'd9, 10'd9, 10'd9, 32'hDEADBEEF, 4'b0001, "R4", 1, 1);
    step(10'd9, 10'd9, 10'd9, 32'hCAFEF00D, 4'b1010, "R4", 1, 1);
    step(10'd9, 10'd8, 10'd8, 32'h01234567, 4'b0100, "R4", 1, 1);
    step(10'd8, 10'd9, 10'd0, 32'h0, 4'b0000, "R4", 1, 1);

    // R5: write with no lanes enabled leaves the word alone.
    step(10'd12, 10'd0, 10'd12, 32'hFFFFFFFF, 4'b0000, "R5", 1, 1);
    step(10'd12, 10'd12, 10'd13, 32'hFFFFFFFF, 4'b0000, "R5", 1, 1);
    step(10'd12, 10'd13, 10'd0, 32'h0, 4'b0000, "R5", 1, 1);

    // R9: equal and distinct addresses on the two ports.
    step(10'd100, 10'd100, 10'd0, 32'h0, 4'h0, "R9", 1, 1);
    step(10'd100, 10'd900, 10'd0, 32'h0, 4'h0, "R9", 1, 1);
    step(10'd1023, 10'd0, 10'd0, 32'h0, 4'h0, "R9", 1, 1);

    // Mixed traffic over a small window to force frequent read-after-write (R3).
    for (int i = 0; i < 3000; i++) begin
      step(ADDR_W'($urandom_range(15)), ADDR_W'($urandom_range(15)),
           ADDR_W'($urandom_range(15)), $urandom, BE_W'($urandom_range(15)),
           "R3", 1, 1);
    end

    // Drain the last two requests (R1).
    step('0, '0, '0, '0, '0, "R1", 1, 1);
    step('0, '0, '0, '0, '0, "R1", 1, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule